// File: doc/BRIEF.md
# Dual-Port RAM with Contention Arbitration

A synchronous true dual-port memory of 2048 words by 16 bits. Two ports, A and B, each have a select, a write strobe, a read-out enable, an address, write data, read data and a stall flag. Both ports reach the array in the same clock cycle. When both ports are selected on the same address, an arbiter lets one of them keep going and raises the stall flag of the other. The stalled port's write is held off until the clash clears.

A `MASTER` parameter chooses the role. A master instance runs its own arbiter and drives the stall outputs. A slave instance has no arbiter. It takes the stall flags from its inputs, typically from a master that watches the same address lines, and uses them only to block writes. All inputs are sampled on the rising clock edge. Read data is registered. A port that is not reading returns zero.

Top module: `twin_port_ram`

## Requirements
- R1: A port with select and read-out enable high at an edge shows, after that edge, the word stored at its address before any write made at the same edge.
- R2: A port writes at an edge when select and write strobe are high and it is not stalled. A later read of that address from either port returns the written word.
- R3: Read data is zero after an edge where the port's select or read-out enable was low, and after reset.
- R4: In master mode a stall output is high only while both selects are high and the two addresses are equal. It falls in the same cycle that the addresses differ or either select drops.
- R5: When a clash begins, the port whose select and address were unchanged since the previous edge keeps access, and the other port is stalled.
- R6: When both ports changed in the cycle the clash begins, port A keeps access and port B is stalled.
- R7: While a clash lasts, the stall stays on the same port.
- R8: A stalled port's write does not change memory. If its request is still held at the edge after the stall clears, the write completes at that edge.
- R9: The two stall outputs are never high together.
- R10: In slave mode both stall outputs stay low, and a port's write is blocked while its stall input is high. In master mode the stall inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_sel | input | 1 | Port A select |
| a_wr | input | 1 | Port A write strobe |
| a_out_en | input | 1 | Port A read-out enable |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_stall_i | input | 1 | Port A external stall (slave mode) |
| a_rdata | output | DW | Port A registered read data |
| a_stall_o | output | 1 | Port A stall flag (master mode) |
| b_sel | input | 1 | Port B select |
| b_wr | input | 1 | Port B write strobe |
| b_out_en | input | 1 | Port B read-out enable |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_stall_i | input | 1 | Port B external stall (slave mode) |
| b_rdata | output | DW | Port B registered read data |
| b_stall_o | output | 1 | Port B stall flag (master mode) |

## Verification
The bench targets three kinds of clash start: A settled first, B settled first, and both arriving in the same cycle. An arbiter that picked the loser from the port number alone, or that recomputed the winner every cycle, would stall the wrong port or hand the stall back and forth during a long clash. A stalled write is checked twice: memory must stay untouched during the clash, and the write must land on the release edge. A design that dropped the held request, or that let it through early, leaves the wrong word behind. Read-before-write on the same edge, zero read data when a port is idle, and a slave whose stall inputs must block writes while a master ignores the same inputs are also driven, along with long runs of random traffic over four addresses.

// File: rtl/twr_pkg.sv
package twr_pkg;
   typedef enum logic {
      WIN_A = 1'b0,
      WIN_B = 1'b1
   } win_e;
endpackage

// File: rtl/twr_arbiter.sv
module twr_arbiter
   import twr_pkg::*;
#(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_sel,
   input  logic [AW-1:0] a_addr,
   input  logic          b_sel,
   input  logic [AW-1:0] b_addr,
   output logic          a_stall,
   output logic          b_stall
);
   logic          a_sel_q, b_sel_q, hit_q;
   logic [AW-1:0] a_addr_q, b_addr_q;
   win_e          win_q, win_now;
   logic          hit, fresh, a_moved, b_moved;

   assign hit     = a_sel && b_sel && (a_addr == b_addr);
   assign fresh   = hit && !hit_q;
   assign a_moved = (a_sel != a_sel_q) || (a_addr != a_addr_q);
   assign b_moved = (b_sel != b_sel_q) || (b_addr != b_addr_q);

   // Earlier arrival wins; a same-cycle arrival goes to port A.
   always_comb begin
      win_now = win_q;
      if (fresh) win_now = (a_moved && !b_moved) ? WIN_B : WIN_A;
   end

   assign a_stall = hit && (win_now == WIN_B);
   assign b_stall = hit && (win_now == WIN_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_sel_q  <= 1'b0;
         b_sel_q  <= 1'b0;
         a_addr_q <= '0;
         b_addr_q <= '0;
         hit_q    <= 1'b0;
         win_q    <= WIN_A;
      end else begin
         a_sel_q  <= a_sel;
         b_sel_q  <= b_sel;
         a_addr_q <= a_addr;
         b_addr_q <= b_addr;
         hit_q    <= hit;
         win_q    <= win_now;
      end
   end
endmodule

// File: rtl/twr_store.sv
module twr_store #(
   parameter int AW    = 11,
   parameter int DW    = 16,
   parameter int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_wen,
   input  logic          a_ren,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_rdata,
   input  logic          b_wen,
   input  logic          b_ren,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata,
   output logic [DW-1:0] b_rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (a_wen) mem[a_addr] <= a_wdata;
      if (b_wen) mem[b_addr] <= b_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rdata <= '0;
         b_rdata <= '0;
      end else begin
         a_rdata <= a_ren ? mem[a_addr] : '0;
         b_rdata <= b_ren ? mem[b_addr] : '0;
      end
   end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
   parameter int AW     = 11,
   parameter int DW     = 16,
   parameter bit MASTER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_sel,
   input  logic          a_wr,
   input  logic          a_out_en,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   input  logic          a_stall_i,
   output logic [DW-1:0] a_rdata,
   output logic          a_stall_o,
   input  logic          b_sel,
   input  logic          b_wr,
   input  logic          b_out_en,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata,
   input  logic          b_stall_i,
   output logic [DW-1:0] b_rdata,
   output logic          b_stall_o
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("twin_port_ram: AW out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("twin_port_ram: DW must be positive");
   end

   logic a_block, b_block;

   if (MASTER) begin : g_master
      logic a_arb, b_arb;
      logic unused_stall_in;
      assign unused_stall_in = a_stall_i ^ b_stall_i;
      twr_arbiter #(.AW(AW)) u_arb (
         .clk    (clk),
         .rst_n  (rst_n),
         .a_sel  (a_sel),
         .a_addr (a_addr),
         .b_sel  (b_sel),
         .b_addr (b_addr),
         .a_stall(a_arb),
         .b_stall(b_arb)
      );
      assign a_block   = a_arb;
      assign b_block   = b_arb;
      assign a_stall_o = a_arb;
      assign b_stall_o = b_arb;
   end else begin : g_slave
      assign a_block   = a_stall_i;
      assign b_block   = b_stall_i;
      assign a_stall_o = 1'b0;
      assign b_stall_o = 1'b0;
   end

   twr_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_wen  (a_sel && a_wr && !a_block),
      .a_ren  (a_sel && a_out_en),
      .a_addr (a_addr),
      .a_wdata(a_wdata),
      .a_rdata(a_rdata),
      .b_wen  (b_sel && b_wr && !b_block),
      .b_ren  (b_sel && b_out_en),
      .b_addr (b_addr),
      .b_wdata(b_wdata),
      .b_rdata(b_rdata)
   );
endmodule

// File: rtl/twr_chk.sv
module twr_chk #(
   parameter int AW     = 11,
   parameter int DW     = 16,
   parameter bit MASTER = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          a_sel,
   input logic          a_out_en,
   input logic [AW-1:0] a_addr,
   input logic [DW-1:0] a_rdata,
   input logic          a_stall_o,
   input logic          b_sel,
   input logic          b_out_en,
   input logic [AW-1:0] b_addr,
   input logic [DW-1:0] b_rdata,
   input logic          b_stall_o
);
   logic clash;
   assign clash = a_sel && b_sel && (a_addr == b_addr);

   // R9
   stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_stall_o && b_stall_o));

   // R4
   stall_needs_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_stall_o || b_stall_o) |-> clash);

   // R7
   a_stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_stall_o |=> (!clash || a_stall_o));

   // R7
   b_stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_stall_o |=> (!clash || b_stall_o));

   // R3
   a_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_sel && a_out_en) |=> (a_rdata == '0));

   // R3
   b_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_sel && b_out_en) |=> (b_rdata == '0));

   if (MASTER) begin : g_m
      // R4
      stall_on_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clash |-> (a_stall_o || b_stall_o));
   end else begin : g_s
      // R10
      slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !a_stall_o && !b_stall_o);
   end
endmodule

bind twin_port_ram twr_chk #(.AW(AW), .DW(DW), .MASTER(MASTER)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .a_sel    (a_sel),
   .a_out_en (a_out_en),
   .a_addr   (a_addr),
   .a_rdata  (a_rdata),
   .a_stall_o(a_stall_o),
   .b_sel    (b_sel),
   .b_out_en (b_out_en),
   .b_addr   (b_addr),
   .b_rdata  (b_rdata),
   .b_stall_o(b_stall_o)
);

// File: tb/twin_port_ram_bench.sv
module twin_port_ram_bench;
   localparam int PERIOD = 10;
   localparam int AW = 11;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_sel = 0, a_wr = 0, a_out_en = 0, b_sel = 0, b_wr = 0, b_out_en = 0;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic [DW-1:0] a_wdata = '0, b_wdata = '0;
   logic a_hold = 0, b_hold = 0;
   logic [DW-1:0] ma_rd, mb_rd, sa_rd, sb_rd;
   logic ma_st, mb_st, sa_st, sb_st;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   twin_port_ram #(.AW(AW), .DW(DW), .MASTER(1'b1)) u_twin_port_ram (
      .clk(clk), .rst_n(rst_n),
      .a_sel(a_sel), .a_wr(a_wr), .a_out_en(a_out_en), .a_addr(a_addr),
      .a_wdata(a_wdata), .a_stall_i(a_hold), .a_rdata(ma_rd), .a_stall_o(ma_st),
      .b_sel(b_sel), .b_wr(b_wr), .b_out_en(b_out_en), .b_addr(b_addr),
      .b_wdata(b_wdata), .b_stall_i(b_hold), .b_rdata(mb_rd), .b_stall_o(mb_st));

   twin_port_ram #(.AW(AW), .DW(DW), .MASTER(1'b0)) u_slave (
      .clk(clk), .rst_n(rst_n),
      .a_sel(a_sel), .a_wr(a_wr), .a_out_en(a_out_en), .a_addr(a_addr),
      .a_wdata(a_wdata), .a_stall_i(a_hold), .a_rdata(sa_rd), .a_stall_o(sa_st),
      .b_sel(b_sel), .b_wr(b_wr), .b_out_en(b_out_en), .b_addr(b_addr),
      .b_wdata(b_wdata), .b_stall_i(b_hold), .b_rdata(sb_rd), .b_stall_o(sb_st));

   // Reference model
   int mmem[int];
   int smem[int];
   int e_ma = 0, e_mb = 0, e_sa = 0, e_sb = 0;
   bit k_ma = 1, k_mb = 1, k_sa = 1, k_sb = 1;
   bit p_as = 0, p_bs = 0, p_hit = 0, p_bl = 0;
   int p_aa = 0, p_ba = 0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit ref_b_loses();
      bit am, bm;
      if (p_hit) return p_bl;
      am = (a_sel != p_as) || (int'(a_addr) != p_aa);
      bm = (b_sel != p_bs) || (int'(b_addr) != p_ba);
      return !(am && !bm);
   endfunction

   function automatic bit ref_hit();
      return a_sel && b_sel && (a_addr == b_addr);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         e_ma = 0; e_mb = 0; e_sa = 0; e_sb = 0;
         k_ma = 1; k_mb = 1; k_sa = 1; k_sb = 1;
         p_as = 0; p_bs = 0; p_hit = 0; p_bl = 0; p_aa = 0; p_ba = 0;
      end else begin
         bit h, bl, awm, bwm;
         h  = ref_hit();
         bl = h ? ref_b_loses() : p_bl;
         if (a_sel && a_out_en) begin
            k_ma = mmem.exists(int'(a_addr)); e_ma = k_ma ? mmem[int'(a_addr)] : 0;
            k_sa = smem.exists(int'(a_addr)); e_sa = k_sa ? smem[int'(a_addr)] : 0;
         end else begin
            k_ma = 1; e_ma = 0; k_sa = 1; e_sa = 0;
         end
         if (b_sel && b_out_en) begin
            k_mb = mmem.exists(int'(b_addr)); e_mb = k_mb ? mmem[int'(b_addr)] : 0;
            k_sb = smem.exists(int'(b_addr)); e_sb = k_sb ? smem[int'(b_addr)] : 0;
         end else begin
            k_mb = 1; e_mb = 0; k_sb = 1; e_sb = 0;
         end
         awm = a_sel && a_wr && !(h && !bl);
         bwm = b_sel && b_wr && !(h && bl);
         if (awm) mmem[int'(a_addr)] = int'(a_wdata);
         if (bwm) mmem[int'(b_addr)] = int'(b_wdata);
         if (a_sel && a_wr && !a_hold) smem[int'(a_addr)] = int'(a_wdata);
         if (b_sel && b_wr && !b_hold) smem[int'(b_addr)] = int'(b_wdata);
         p_hit = h; p_bl = bl;
         p_as = a_sel; p_bs = b_sel; p_aa = int'(a_addr); p_ba = int'(b_addr);
      end
   end

   // Per-clock comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit h, bl;
         h  = ref_hit();
         bl = h ? ref_b_loses() : 1'b0;
         chk("R4", int'(ma_st), int'(h && !bl));
         chk("R4", int'(mb_st), int'(h && bl));
         chk("R9", int'(ma_st && mb_st), 0);
         chk("R10", int'(sa_st || sb_st), 0);
         if (k_ma) chk("R1", int'(ma_rd), e_ma);
         if (k_mb) chk("R1", int'(mb_rd), e_mb);
         if (k_sa) chk("R10", int'(sa_rd), e_sa);
         if (k_sb) chk("R10", int'(sb_rd), e_sb);
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_a(input bit s, input bit w, input bit o, input int ad, input int d);
      a_sel = s; a_wr = w; a_out_en = o; a_addr = AW'(ad); a_wdata = DW'(d);
   endtask

   task automatic set_b(input bit s, input bit w, input bit o, input int ad, input int d);
      b_sel = s; b_wr = w; b_out_en = o; b_addr = AW'(ad); b_wdata = DW'(d);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      tick(); tick(); tick();
      rst_n = 1'b1;
      #1;
      chk("R3", int'(ma_rd), 0);
      chk("R3", int'(mb_rd), 0);

      // Port-to-port visibility
      set_a(1, 1, 0, 5, 'h1111); set_b(1, 1, 0, 9, 'h2222); tick();
      set_a(1, 0, 1, 9, 0); set_b(1, 0, 1, 5, 0); tick();
      chk("R2", int'(ma_rd), 'h2222);
      chk("R2", int'(mb_rd), 'h1111);
      // Read-before-write on the same edge
      set_a(1, 1, 1, 5, 'h3333); set_b(0, 0, 0, 0, 0); tick();
      chk("R1", int'(ma_rd), 'h1111);
      set_a(1, 0, 1, 5, 0); tick();
      chk("R2", int'(ma_rd), 'h3333);
      // Idle read gating
      set_a(1, 0, 0, 5, 0); tick();
      chk("R3", int'(ma_rd), 0);
      set_a(0, 0, 1, 5, 0); tick();
      chk("R3", int'(ma_rd), 0);

      // Clash with A first
      set_a(1, 1, 0, 20, 0); tick();
      set_a(1, 0, 1, 20, 0); tick();
      set_b(1, 1, 0, 20, 'hBEEF); #1;
      chk("R5", int'(mb_st), 1);
      chk("R5", int'(ma_st), 0);
      tick();
      chk("R8", int'(ma_rd), 0);
      for (int i = 0; i < 3; i++) begin
         chk("R7", int'(mb_st), 1);
         tick();
         chk("R8", int'(ma_rd), 0);
      end
      set_a(1, 0, 1, 21, 0); #1;
      chk("R4", int'(mb_st), 0);
      tick();
      set_a(1, 0, 1, 20, 0); set_b(0, 0, 0, 0, 0); tick();
      chk("R8", int'(ma_rd), 'hBEEF);

      // Clash with B first
      set_a(0, 0, 0, 0, 0); set_b(1, 1, 0, 30, 'h0030); tick();
      set_b(1, 0, 1, 30, 0); tick();
      set_a(1, 1, 0, 30, 'h7777); #1;
      chk("R5", int'(ma_st), 1);
      chk("R5", int'(mb_st), 0);
      tick();
      set_a(0, 0, 0, 0, 0); #1;
      chk("R4", int'(ma_st), 0);
      tick();
      chk("R8", int'(mb_rd), 'h0030);

      // Same-cycle arrival
      set_b(0, 0, 0, 0, 0); tick();
      set_a(1, 1, 0, 40, 'hAAAA); set_b(1, 1, 0, 40, 'hBBBB); #1;
      chk("R6", int'(mb_st), 1);
      chk("R6", int'(ma_st), 0);
      tick();
      set_a(1, 0, 1, 40, 0); set_b(0, 0, 0, 0, 0); tick();
      chk("R6", int'(ma_rd), 'hAAAA);

      // Slave blocking and master ignoring stall inputs
      set_a(1, 1, 0, 50, 'h0050); set_b(1, 1, 0, 51, 'h0051); tick();
      b_hold = 1;
      set_a(1, 1, 0, 51, 'h5151); set_b(1, 1, 0, 50, 'h5050); #1;
      chk("R10", int'(sa_st || sb_st), 0);
      tick();
      b_hold = 0;
      set_a(1, 0, 1, 50, 0); set_b(1, 0, 1, 51, 0); tick();
      chk("R10", int'(ma_rd), 'h5050);
      chk("R10", int'(sa_rd), 'h0050);
      chk("R10", int'(sb_rd), 'h5151);

      // Random traffic over a small address window
      for (int i = 0; i < 2000; i++) begin
         set_a(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 4, $urandom);
         set_b(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 4, $urandom);
         a_hold = ($urandom % 4) == 0;
         b_hold = ($urandom % 4) == 0;
         if (a_sel && b_sel && a_wr && b_wr && a_addr == b_addr && !a_hold && !b_hold)
            b_hold = 1;
         tick();
      end

      done = 1;
      summary();
      $finish;
   end
endmodule